// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Set-Less-Than

This block is a purely combinational integer arithmetic logic unit. The datapath is made of identical one-bit slices, one slice per operand bit, and the carry ripples from each slice into the next. A three-bit operation code selects bitwise AND, bitwise OR, addition, subtraction, or a signed less-than compare. In each slice a multiplexer picks the slice's result bit from the AND gate, the OR gate, the full-adder sum, or a less-than input. The less-than input of bit 0 comes from the sign logic at the top of the chain.

Subtraction inverts the second operand and forces a carry of one into bit 0, which forms the two's-complement negation. The compare runs that same subtraction. The compare result is the sign of the difference corrected by the signed overflow, so it is right over the whole signed range. It is placed in bit 0 and every higher result bit is cleared. A zero flag lets a branch test equality by subtracting and checking the flag. Carry-out and overflow flags describe the adder's operation.

Top module: `slice_alu`

## Requirements
- R1: Code 3'b000 drives result to the bitwise AND of opA and opB.
- R2: Code 3'b001 drives result to the bitwise OR of opA and opB.
- R3: Code 3'b010 drives result to opA + opB modulo 2^WIDTH.
- R4: Code 3'b110 drives result to opA - opB modulo 2^WIDTH.
- R5: Code 3'b111 drives result[0] to 1 when opA is less than opB as signed two's-complement numbers, and to 0 otherwise. All higher result bits are 0. The compare is correct even when opA - opB overflows.
- R6: zeroFlag is 1 exactly when every result bit is 0, for every code.
- R7: carryOut is the carry out of the most significant adder position, for every code. The adder forms opA + opB when code bit 2 is 0. It forms opA + ~opB + 1 when code bit 2 is 1.
- R8: overflowFlag is 1 exactly when the adder operation of R7 overflows as a signed operation, for every code.
- R9: The unlisted codes 3'b011, 3'b100 and 3'b101 drive result to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand (subtrahend for subtract and compare) |
| aluCode | input | 3 | Operation select code |
| result | output | WIDTH | Selected operation result |
| zeroFlag | output | 1 | High when result is all zeros |
| carryOut | output | 1 | Carry out of the top adder slice |
| overflowFlag | output | 1 | Signed overflow of the adder operation |

## Verification
The bench builds the block with WIDTH at its default of 32. With that width the signed range ends at 32'h7FFFFFFF and 32'h80000000. Operands at those ends make the subtraction overflow, so the bench can show that the compare is corrected by the overflow term rather than read from the sign bit. Every slice is on the carry path, so operands that ripple a carry across the full width, such as all ones plus one, exercise every carry link between slices.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

  localparam logic [2:0] CODE_AND = 3'b000;
  localparam logic [2:0] CODE_OR  = 3'b001;
  localparam logic [2:0] CODE_ADD = 3'b010;
  localparam logic [2:0] CODE_SUB = 3'b110;
  localparam logic [2:0] CODE_SLT = 3'b111;

  typedef enum logic [2:0] {
    PICK_AND  = 3'd0,
    PICK_OR   = 3'd1,
    PICK_SUM  = 3'd2,
    PICK_LESS = 3'd3,
    PICK_ZERO = 3'd4
  } pick_e;

  typedef struct packed {
    logic  bInvert;
    logic  carryIn;
    pick_e pick;
  } aluStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import slice_alu_pkg::*;
(
  input  logic [2:0]  aluCode,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes.bInvert = aluCode[2];
    strobes.carryIn = aluCode[2];
    unique case (aluCode)
      CODE_AND: strobes.pick = PICK_AND;
      CODE_OR:  strobes.pick = PICK_OR;
      CODE_ADD: strobes.pick = PICK_SUM;
      CODE_SUB: strobes.pick = PICK_SUM;
      CODE_SLT: strobes.pick = PICK_LESS;
      default:  strobes.pick = PICK_ZERO;
    endcase
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import slice_alu_pkg::*;
(
  input  logic  a,
  input  logic  b,
  input  logic  carryIn,
  input  logic  bInvert,
  input  logic  lessIn,
  input  pick_e pick,
  output logic  resBit,
  output logic  sumBit,
  output logic  carryOut
);

  logic bEff;

  assign bEff     = b ^ bInvert;
  assign sumBit   = a ^ bEff ^ carryIn;
  assign carryOut = (a & bEff) | (a & carryIn) | (bEff & carryIn);

  always_comb begin
    unique case (pick)
      PICK_AND:  resBit = a & bEff;
      PICK_OR:   resBit = a | bEff;
      PICK_SUM:  resBit = sumBit;
      PICK_LESS: resBit = lessIn;
      default:   resBit = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import slice_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             carryOut,
  output logic             overflowFlag
);

  localparam int MSB = WIDTH - 1;

  logic setLess;
  logic msbCarryIn;
  logic msbCarryOut;
  logic msbSum;

  for (genvar i = 0; i < WIDTH; i++) begin : slices
    logic cin;
    logic cout;
    logic sum;
    logic less;

    if (i == 0) begin : g_first
      assign cin  = strobes.carryIn;
      assign less = setLess;
    end else begin : g_rest
      assign cin  = slices[i-1].cout;
      assign less = 1'b0;
    end

    alu_bit_slice u_slice (
      .a        (opA[i]),
      .b        (opB[i]),
      .carryIn  (cin),
      .bInvert  (strobes.bInvert),
      .lessIn   (less),
      .pick     (strobes.pick),
      .resBit   (result[i]),
      .sumBit   (sum),
      .carryOut (cout)
    );
  end

  assign msbCarryIn   = slices[MSB].cin;
  assign msbCarryOut  = slices[MSB].cout;
  assign msbSum       = slices[MSB].sum;

  assign overflowFlag = msbCarryIn ^ msbCarryOut;
  assign carryOut     = msbCarryOut;
  assign setLess      = msbSum ^ overflowFlag;
  assign zeroFlag     = ~|result;

endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       aluCode,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             carryOut,
  output logic             overflowFlag
);

  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .aluCode (aluCode),
    .strobes (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA          (opA),
    .opB          (opB),
    .strobes      (strobes),
    .result       (result),
    .zeroFlag     (zeroFlag),
    .carryOut     (carryOut),
    .overflowFlag (overflowFlag)
  );

endmodule

// File: rtl/slice_alu_checker.sv
module slice_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       aluCode,
  input logic [WIDTH-1:0] result,
  input logic             zeroFlag,
  input logic             carryOut,
  input logic             overflowFlag
);

  logic [WIDTH:0] wideSum;
  logic [WIDTH-1:0] bSel;
  logic signedOvf;

  always_comb begin
    bSel      = aluCode[2] ? ~opB : opB;
    wideSum   = {1'b0, opA} + {1'b0, bSel} + {{WIDTH{1'b0}}, aluCode[2]};
    signedOvf = (opA[WIDTH-1] == bSel[WIDTH-1]) && (wideSum[WIDTH-1] != opA[WIDTH-1]);
  end

  always_comb begin
    if (aluCode == 3'b000) begin
      // R1
      and_result_chk: assert (result == (opA & opB)) else $error("and_result_chk");
    end
    if (aluCode == 3'b001) begin
      // R2
      or_result_chk: assert (result == (opA | opB)) else $error("or_result_chk");
    end
    if (aluCode == 3'b110) begin
      // R4
      sub_eq_chk: assert (zeroFlag == (opA == opB)) else $error("sub_eq_chk");
    end
    if (aluCode == 3'b111) begin
      // R5
      slt_value_chk: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))})
        else $error("slt_value_chk");
    end
    if (aluCode == 3'b011 || aluCode == 3'b100 || aluCode == 3'b101) begin
      // R9
      unlisted_zero_chk: assert (result == '0 && zeroFlag) else $error("unlisted_zero_chk");
    end
    // R7
    carry_out_chk: assert (carryOut == wideSum[WIDTH]) else $error("carry_out_chk");
    // R8
    overflow_chk: assert (overflowFlag == signedOvf) else $error("overflow_chk");
  end

endmodule

bind slice_alu slice_alu_checker #(.WIDTH(WIDTH)) u_checker (
  .opA          (opA),
  .opB          (opB),
  .aluCode      (aluCode),
  .result       (result),
  .zeroFlag     (zeroFlag),
  .carryOut     (carryOut),
  .overflowFlag (overflowFlag)
);

// File: tb/slice_alu_bench.sv
module slice_alu_bench;

  localparam int WIDTH = 32;
  localparam int NVEC  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [WIDTH-1:0] opA, opB, result;
  logic [2:0]       aluCode;
  logic             zeroFlag, carryOut, overflowFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  slice_alu #(.WIDTH(WIDTH)) u_slice_alu (
    .opA          (opA),
    .opB          (opB),
    .aluCode      (aluCode),
    .result       (result),
    .zeroFlag     (zeroFlag),
    .carryOut     (carryOut),
    .overflowFlag (overflowFlag)
  );

  // stimulus {code, a, b}
  localparam logic [66:0] VEC [NVEC] = '{
    {3'b000, 32'hF0F0_1234, 32'h0FF0_FF00},
    {3'b001, 32'hF000_0001, 32'h0000_F010},
    {3'b010, 32'h0000_0005, 32'h0000_0007},
    {3'b010, 32'hFFFF_FFFF, 32'h0000_0001},
    {3'b010, 32'h7FFF_FFFF, 32'h0000_0001},
    {3'b010, 32'h8000_0000, 32'h8000_0000},
    {3'b110, 32'h0000_0009, 32'h0000_0004},
    {3'b110, 32'h0000_0004, 32'h0000_0009},
    {3'b110, 32'h8000_0000, 32'h0000_0001},
    {3'b110, 32'h1234_5678, 32'h1234_5678},
    {3'b111, 32'hFFFF_FFFF, 32'h0000_0001},
    {3'b111, 32'h0000_0001, 32'hFFFF_FFFF},
    {3'b111, 32'h8000_0000, 32'h7FFF_FFFF},
    {3'b111, 32'h7FFF_FFFF, 32'h8000_0000},
    {3'b111, 32'h0000_0042, 32'h0000_0042},
    {3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
  };

  function automatic logic [WIDTH+2:0] model(input logic [2:0] c,
                                             input logic [WIDTH-1:0] a,
                                             input logic [WIDTH-1:0] b);
    logic [WIDTH-1:0] bb, r;
    logic [WIDTH:0]   s;
    logic             ovf;
    bb  = c[2] ? ~b : b;
    s   = {1'b0, a} + {1'b0, bb} + {{WIDTH{1'b0}}, c[2]};
    ovf = (a[WIDTH-1] == bb[WIDTH-1]) && (s[WIDTH-1] != a[WIDTH-1]);
    case (c)
      3'b000:  r = a & b;
      3'b001:  r = a | b;
      3'b010:  r = a + b;
      3'b110:  r = a - b;
      3'b111:  r = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = '0;
    endcase
    return {r, (r == '0), s[WIDTH], ovf};
  endfunction

  function automatic string reqOf(input logic [2:0] c);
    case (c)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b110:  return "R4";
      3'b111:  return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic checkOne(input logic [2:0] c, input logic [WIDTH-1:0] a,
                          input logic [WIDTH-1:0] b);
    logic [WIDTH+2:0] exp;
    @(posedge clk);
    aluCode = c; opA = a; opB = b;
    @(negedge clk);
    exp = model(c, a, b);
    testsRun++;
    if (result !== exp[WIDTH+2:3]) begin
      testsFailed++;
      $display("FAIL %s result code=%b a=%h b=%h actual=%h expected=%h",
               reqOf(c), c, a, b, result, exp[WIDTH+2:3]);
    end
    testsRun++;
    if (zeroFlag !== exp[2]) begin
      testsFailed++;
      $display("FAIL R6 zeroFlag code=%b actual=%b expected=%b", c, zeroFlag, exp[2]);
    end
    testsRun++;
    if (carryOut !== exp[1]) begin
      testsFailed++;
      $display("FAIL R7 carryOut code=%b actual=%b expected=%b", c, carryOut, exp[1]);
    end
    testsRun++;
    if (overflowFlag !== exp[0]) begin
      testsFailed++;
      $display("FAIL R8 overflowFlag code=%b actual=%b expected=%b", c, overflowFlag, exp[0]);
    end
  endtask

  task automatic expectBit(input string tag, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    opA = '0; opB = '0; aluCode = 3'b000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // idle state with zero inputs: R1 and R6
    testsRun++;
    if (result !== '0) begin
      testsFailed++;
      $display("FAIL R1 idle result actual=%h expected=0", result);
    end
    expectBit("R6 idle zeroFlag", zeroFlag, 1'b1);

    for (int i = 0; i < NVEC; i++)
      checkOne(VEC[i][66:64], VEC[i][63:32], VEC[i][31:0]);

    // directed corners
    checkOne(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
    expectBit("R6 add wrap zero", zeroFlag, 1'b1);
    expectBit("R7 add wrap carry", carryOut, 1'b1);
    checkOne(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
    expectBit("R8 add overflow", overflowFlag, 1'b1);
    checkOne(3'b111, 32'h8000_0000, 32'h7FFF_FFFF);
    expectBit("R5 slt overflowed compare", result[0], 1'b1);
    checkOne(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);
    expectBit("R5 slt overflowed compare reverse", result[0], 1'b0);
    checkOne(3'b110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    expectBit("R6 equality via subtract", zeroFlag, 1'b1);
    checkOne(3'b100, 32'hFFFF_FFFF, 32'h1234_5678);
    checkOne(3'b101, 32'hAAAA_AAAA, 32'h5555_5555);
    checkOne(3'b011, 32'h0000_0001, 32'h0000_0001);
    expectBit("R9 unlisted zero flag", zeroFlag, 1'b1);

    for (int k = 0; k < 400; k++) begin
      logic [2:0] c;
      c = 3'($urandom_range(0, 7));
      if (k % 8 == 0) checkOne(c, 32'h8000_0000 ^ $urandom, $urandom);
      else            checkOne(c, $urandom, $urandom);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule